// File: doc/BRIEF.md
# Indirect Colour Lookup Table Loader

This block is a colour lookup table of 256 entries, 24 bits each, sitting behind a 32-bit register bus. Software reaches its internal state through two words only: a select word that names a target, and a data word whose writes are steered to that target. The targets are a write-address register, the palette RAM, a per-entry pixel read mask table and a control register.

A colour is loaded in steps. First an index is written through the write-address target while the control register holds the value that arms the index latch. Then three bytes are written through the palette target, in the order red, green, blue. The entry is written only when the third byte arrives, so the table never holds a partly updated colour. A separate lookup port turns a pixel index into its committed 24-bit colour and mask byte one clock later. A read of the identification word returns a fixed value, which lets software detect that the block is present.

Top module: `clut_loader`

## Requirements
- R1: A write at byte offset 0x47EC loads the select word with all 32 bits; every write at byte offset 0x47E8 is routed by the select value most recently written.
- R2: With select equal to 0x06, a data write loads all 32 bits into the control register; the index latch is armed only when control equals exactly 0x0000000F, so a value such as 0x1000000F leaves it disarmed.
- R3: With select equal to 0x00 and control equal to 0x0000000F, a data write sets the palette index to data bits 7:0 and returns the colour byte counter to 0, discarding any partly loaded triplet; with any other control value the index and counter are unchanged.
- R4: With select equal to 0x01, each data write stages data bits 7:0 as red, then green, then blue; the third write stores the entry at the current index as {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R5: After a store the byte counter is back at 0 and the index is kept, so a further triplet overwrites the same entry.
- R6: With select equal to 0x02, a data write stores data bits 7:0 into the mask table at the current palette index.
- R7: Data writes under any select value other than 0x00, 0x01, 0x02, 0x06, and writes to any offset other than 0x47E8 and 0x47EC, change no table entry, index, counter or staged byte.
- R8: The lookup port returns the colour and mask of the entry named by lk_idx on the clock after lk_idx is presented.
- R9: A read at byte offset 0x0014 returns 0x033C0000 on the clock after rd_en; any other read, and any cycle without rd_en, returns 0.
- R10: Reset clears the select word, control, index, byte counter, staged bytes, read data and every mask table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 16 | Byte offset of the read |
| rd_data | output | 32 | Read data, valid the clock after rd_en |
| lk_idx | input | 8 | Pixel index for lookup |
| lk_rgb | output | 24 | Committed colour of the looked-up entry |
| lk_mask | output | 8 | Mask byte of the looked-up entry |

## Verification
The assertions assume that a bus write and a lookup of the entry being stored never fall in the same cycle, and that the bus carries at most one write per cycle at a single offset. The stimulus drives every bus access for exactly one cycle from the falling edge, and looks up an entry only after the cycle that stored it. Entries of the colour table that were never stored have no defined value, so the stimulus only looks up entries it has loaded, while mask entries are checked anywhere since reset defines them.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int RGB_W  = 3 * BYTE_W;

    localparam logic [REG_W-1:0] TGT_WADDR = 32'h0000_0000;
    localparam logic [REG_W-1:0] TGT_PAL   = 32'h0000_0001;
    localparam logic [REG_W-1:0] TGT_MASK  = 32'h0000_0002;
    localparam logic [REG_W-1:0] TGT_CTRL  = 32'h0000_0006;

    localparam logic [REG_W-1:0] CTRL_ARM  = 32'h0000_000F;
    localparam logic [REG_W-1:0] ID_WORD   = 32'h033C_0000;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;
endpackage

// File: rtl/clut_ctrl_regs.sv
module clut_ctrl_regs
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic              dat_wr,
    input  logic [REG_W-1:0]  wdata,
    output logic              pal_we,
    output logic [IDX_W-1:0]  pal_idx,
    output logic [RGB_W-1:0]  pal_rgb,
    output logic              msk_we,
    output logic [BYTE_W-1:0] msk_val
);
    typedef struct packed {
        logic [REG_W-1:0]  tgt;
        logic [REG_W-1:0]  ctrl;
        logic [IDX_W-1:0]  idx;
        phase_e            phase;
        logic [BYTE_W-1:0] stg_r;
        logic [BYTE_W-1:0] stg_g;
    } regs_t;

    regs_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        pal_we  = 1'b0;
        msk_we  = 1'b0;
        pal_rgb = {st_q.stg_r, st_q.stg_g, wdata[BYTE_W-1:0]};
        msk_val = wdata[BYTE_W-1:0];
        if (sel_wr) begin
            st_d.tgt = wdata;
        end else if (dat_wr) begin
            case (st_q.tgt)
                TGT_CTRL: st_d.ctrl = wdata;
                TGT_WADDR: begin
                    if (st_q.ctrl == CTRL_ARM) begin
                        st_d.idx   = wdata[IDX_W-1:0];
                        st_d.phase = PH_RED;
                    end
                end
                TGT_PAL: begin
                    case (st_q.phase)
                        PH_RED: begin
                            st_d.stg_r = wdata[BYTE_W-1:0];
                            st_d.phase = PH_GREEN;
                        end
                        PH_GREEN: begin
                            st_d.stg_g = wdata[BYTE_W-1:0];
                            st_d.phase = PH_BLUE;
                        end
                        default: begin
                            pal_we     = 1'b1;
                            st_d.phase = PH_RED;
                        end
                    endcase
                end
                TGT_MASK: msk_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pal_idx = st_q.idx;

    p_phase_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase != 2'd3);

    p_store_rewinds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> (st_q.phase == PH_RED) && (st_q.idx == $past(st_q.idx)));

    p_idx_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr && st_q.tgt == TGT_WADDR && st_q.ctrl == CTRL_ARM) |=> $stable(st_q.idx));

    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !sel_wr && st_q.tgt == TGT_CTRL) |=> st_q.ctrl == $past(wdata));

    p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pal_we && msk_we));
endmodule

// File: rtl/clut_color_ram.sv
module clut_color_ram
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [RGB_W-1:0] rdata
);
    logic [RGB_W-1:0] mem_q [ENTRIES];
    logic [RGB_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rd_q <= mem_q[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/clut_mask_tbl.sv
module clut_mask_tbl
    import clut_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] tbl_q [ENTRIES];
    logic [BYTE_W-1:0] tbl_d [ENTRIES];
    logic [BYTE_W-1:0] rd_q, rd_d;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_comb begin
            tbl_d[g] = tbl_q[g];
            if (we && waddr == IDX_W'(g)) begin
                tbl_d[g] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[g] <= '0;
            end else begin
                tbl_q[g] <= tbl_d[g];
            end
        end
    end

    assign rd_d = tbl_q[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

    p_mask_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && raddr == waddr) ##1 (raddr == $past(waddr)) |=> rdata == $past(wdata, 2));
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int              ENTRIES  = 256,
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] OFS_SEL  = 16'h47EC,
    parameter logic [ADDR_W-1:0] OFS_DATA = 16'h47E8,
    parameter logic [ADDR_W-1:0] OFS_ID   = 16'h0014,
    localparam int             IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [RGB_W-1:0]  lk_rgb,
    output logic [BYTE_W-1:0] lk_mask
);
    logic              sel_wr, dat_wr;
    logic              pal_we, msk_we;
    logic [IDX_W-1:0]  pal_idx;
    logic [RGB_W-1:0]  pal_rgb;
    logic [BYTE_W-1:0] msk_val;
    logic [REG_W-1:0]  rd_data_q, rd_data_d;

    assign sel_wr = wr_en && (wr_addr == OFS_SEL);
    assign dat_wr = wr_en && (wr_addr == OFS_DATA);

    clut_ctrl_regs #(.ENTRIES(ENTRIES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (sel_wr),
        .dat_wr  (dat_wr),
        .wdata   (wr_data),
        .pal_we  (pal_we),
        .pal_idx (pal_idx),
        .pal_rgb (pal_rgb),
        .msk_we  (msk_we),
        .msk_val (msk_val)
    );

    clut_color_ram #(.ENTRIES(ENTRIES)) u_ram (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_idx),
        .wdata (pal_rgb),
        .raddr (lk_idx),
        .rdata (lk_rgb)
    );

    clut_mask_tbl #(.ENTRIES(ENTRIES)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (msk_we),
        .waddr (pal_idx),
        .wdata (msk_val),
        .raddr (lk_idx),
        .rdata (lk_mask)
    );

    always_comb begin
        rd_data_d = '0;
        if (rd_en && rd_addr == OFS_ID) begin
            rd_data_d = ID_WORD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data = rd_data_q;

    p_id_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_ID) |=> rd_data == ID_WORD);

    p_other_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == OFS_ID) |=> rd_data == '0);

    p_ignored_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_wr |-> !(pal_we || msk_we));
endmodule

// File: tb/clut_loader_bench.sv
module clut_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  lk_idx = '0;
    logic [23:0] lk_rgb;
    logic [7:0]  lk_mask;

    localparam logic [15:0] A_SEL  = 16'h47EC;
    localparam logic [15:0] A_DATA = 16'h47E8;

    typedef struct {
        int          kind;   // 0 colour, 1 mask, 2 read data
        string       req;
        logic [31:0] exp;
    } item_t;

    item_t       sb[$];
    logic        probe = 1'b0;
    logic        probe_seen = 1'b0;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    clut_loader u_clut_loader (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .lk_idx(lk_idx), .lk_rgb(lk_rgb), .lk_mask(lk_mask)
    );

    always @(posedge clk) probe_seen <= probe;

    // monitor: compares outputs one clock after each probe
    always @(negedge clk) begin
        if (probe_seen && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = {8'h00, lk_rgb};
                1:       act = {24'h0, lk_mask};
                default: act = rd_data;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pick(input logic [31:0] code);
        bus_wr(A_SEL, code);
    endtask

    task automatic put(input logic [31:0] d);
        bus_wr(A_DATA, d);
    endtask

    task automatic look(input int kind, input logic [7:0] idx,
                        input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        lk_idx = idx;
        it.kind = kind; it.req = req; it.exp = exp;
        sb.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        it.kind = 2; it.req = req; it.exp = exp;
        sb.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; probe = 1'b0;
    endtask

    task automatic rgb3(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        put({24'hFFFF00, r}); put({24'h0, g}); put({24'hABCD00, b});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        look(1, 8'h00, 32'h0, "R10 mask cleared idx 00");
        look(1, 8'hFF, 32'h0, "R10 mask cleared idx FF");
        // R9 identification read
        rd(16'h0014, 32'h033C_0000, "R9 id word");
        rd(16'h0018, 32'h0, "R9 other offset reads 0");
        rd(16'h47E8, 32'h0, "R9 data reg reads 0");

        // R2 arm index latch, R3 index write, R4 triplet, R1 routing
        pick(32'h6); put(32'hF);
        pick(32'h0); put(32'h0000_0110);
        pick(32'h1); rgb3(8'hAA, 8'hBB, 8'hCC);
        look(0, 8'h10, 32'h00AABBCC, "R4 R1 entry 10 stored RGB");
        // R5 overwrite same entry
        rgb3(8'h11, 8'h22, 8'h33);
        look(0, 8'h10, 32'h00112233, "R5 second triplet same entry");
        // R3 partial triplet discarded by new index
        put(32'h01);
        pick(32'h0); put(32'h20);
        pick(32'h1); rgb3(8'h44, 8'h55, 8'h66);
        look(0, 8'h20, 32'h00445566, "R3 counter reset by index write");
        // R6 mask write at current index
        pick(32'h2); put(32'h1F5);
        look(1, 8'h20, 32'hF5, "R6 mask at index 20");
        look(1, 8'h10, 32'h00, "R6 other mask untouched");
        // R3 disarmed latch: control 7
        pick(32'h6); put(32'h7);
        pick(32'h0); put(32'h30);
        pick(32'h1); rgb3(8'h77, 8'h88, 8'h99);
        look(0, 8'h20, 32'h00778899, "R3 index held when control not armed");
        // R2 full 32-bit compare
        pick(32'h6); put(32'h1000_000F);
        pick(32'h0); put(32'h40);
        pick(32'h2); put(32'h3C);
        look(1, 8'h20, 32'h3C, "R2 upper control bits disarm latch");
        look(1, 8'h40, 32'h00, "R2 index 40 mask untouched");
        // R7 unknown select codes
        pick(32'h3); put(32'h5A);
        pick(32'h5); put(32'h5B);
        pick(32'h101); put(32'h5C);
        look(1, 8'h20, 32'h3C, "R7 unknown select leaves mask");
        look(0, 8'h20, 32'h00778899, "R7 unknown select leaves colour");
        // R7 unmapped offset writes while palette selected
        pick(32'h1);
        bus_wr(16'h47E4, 32'hDE); bus_wr(16'h47F0, 32'hDE); bus_wr(16'h0014, 32'hDE);
        look(0, 8'h20, 32'h00778899, "R7 unmapped offsets no store");
        rgb3(8'h01, 8'h02, 8'h03);
        look(0, 8'h20, 32'h00010203, "R7 counter not advanced by unmapped writes");
        // R8 back-to-back lookups
        look(0, 8'h10, 32'h00112233, "R8 lookup idx 10");
        look(0, 8'h20, 32'h00010203, "R8 lookup idx 20");
        look(1, 8'h20, 32'h3C, "R8 mask lookup idx 20");
        // R10 reset mid run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(1, 8'h20, 32'h00, "R10 mask cleared after reset");
        // after reset control is 0: index write must not arm, select is 0x00
        put(32'h77);
        pick(32'h2); put(32'h9);
        look(1, 8'h00, 32'h09, "R10 index and select cleared");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        finish_run();
    end
endmodule